// File: doc/BRIEF.md
# Two-Tier Fair Bus Arbiter

This block decides which of several masters may drive a shared parallel bus next. Every master raises its request by pulling its own active-low request line low. It learns that it has won when its own active-low grant line goes low. The masters fall into two tiers. Tier one holds the masters that use the bus often, and tier two holds those that use it rarely. In rotational mode the tier-one masters take turns. After each full pass through tier one, a single tier-two master gets a turn, and the tier-two masters also take turns among themselves. A fixed-priority mode is also available, and in that mode the lowest index wins.

The grant can move while another master still owns the bus, so arbitration stays hidden behind the current transfer. A master that holds the grant begins only once it sees the bus idle. Frame and initiator-ready are both active low, so an idle bus shows both of them high. The arbiter counts a grant as used when frame is sampled low after a cycle in which frame and initiator-ready were both high. When that happens the arbiter re-arbitrates at once. The owner sees its grant disappear, and it reads that as a request to hand the bus over when its own timer expires. When nobody requests, the grant is parked. It goes either on a master chosen by configuration or on the master that held the grant last.

Top module: `bus_arb_two_tier`

## Requirements
- R1: The grant lines are active low. At most one bit of `gnt_n` is low in any cycle.
- R2: While `rst_n` is low, every bit of `gnt_n` is high. At the first clock edge after reset is released with no request pending, master 0 receives the grant, whatever the park setting.
- R3: The arbiter samples requests at a clock edge, and the resulting grant shows on `gnt_n` straight after that same edge.
- R4: A master that holds the grant keeps it for as long as it keeps requesting and has not yet started a transfer. A start means `frame_n` is sampled low at an edge, and at the edge before it `frame_n` and `irdy_n` were both high.
- R5: At the edge where a start is detected, the arbiter makes a new decision. The grant may therefore move to another master while `frame_n` and `irdy_n` are still low.
- R6: With `cfg_rotate`=1, tier one is indices 0..N_HI-1 and tier two is indices N_HI..N_HI+N_LO-1. With every master requesting, the grants follow this order: tier-one masters in index order, then the next tier-two master in rotation, then tier one again. With N_HI=N_LO=3 and masters 0,1,3,4,5 requesting, the order is 0 1 3 0 1 4 0 1 5 0 1 3.
- R7: A master that is not requesting loses its turn, and the next requester of the same tier takes that turn with no idle cycle. If tier two has no requester, tier one keeps rotating. If tier one has no requester, tier two rotates alone.
- R8: With `cfg_rotate`=0, the lowest-index requesting master wins every decision.
- R9: With `cfg_park_last`=0 and no request pending, the grant parks on master `cfg_park_id` (the value must be below N_HI+N_LO). The exception is the first grant after reset, which R2 covers.
- R10: With `cfg_park_last`=1 and no request pending, the master that holds the grant keeps it.
- R11: If the master holding the grant stops requesting while another master requests, the grant moves to one of the requesters at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_n | input | N_HI+N_LO | Active-low request, one bit per master |
| frame_n | input | 1 | Active-low frame of the shared bus |
| irdy_n | input | 1 | Active-low initiator-ready of the shared bus |
| cfg_rotate | input | 1 | 1 selects two-tier rotation, 0 selects fixed priority |
| cfg_park_last | input | 1 | 1 parks on the last holder of the grant, 0 parks on `cfg_park_id` |
| cfg_park_id | input | clog2(N_HI+N_LO) | Index of the master used for fixed parking |
| gnt_n | output | N_HI+N_LO | Active-low grant, one bit per master |

## Verification
Two events can land on the same edge. One is the start detection that consumes a grant. The other is the holder dropping its request or the bus going quiet so that parking applies. The bench provokes both together by randomising requests, frame and initiator-ready every cycle while the configuration changes now and then. It also runs a directed hidden-arbitration case in which the grant moves while frame and initiator-ready are still low. After every edge it compares the grant against a model that it builds from the requirements, and it runs directed orderings that check the nested rotation, turn skipping, fixed priority and both parking modes against expected index lists.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Source of the grant decision taken at the coming edge
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_PARK = 3'd1,
    SRC_FIX  = 3'd2,
    SRC_HI   = 3'd3,
    SRC_LO   = 3'd4
  } pick_src_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Finds the first requester strictly after ptr, wrapping around
module arb_rr_pick #(
  parameter  int W  = 3,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= W; k++) begin
      int c;
      c = (int'(ptr) + k) % W;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end

endmodule

// File: rtl/arb_prio_pick.sv
// Lowest set index wins
module arb_prio_pick #(
  parameter  int W  = 6,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/bus_arb_two_tier.sv
module bus_arb_two_tier #(
  parameter  int N_HI = 3,
  parameter  int N_LO = 3,
  localparam int N    = N_HI + N_LO,
  localparam int IDW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_n,
  input  logic           frame_n,
  input  logic           irdy_n,
  input  logic           cfg_rotate,
  input  logic           cfg_park_last,
  input  logic [IDW-1:0] cfg_park_id,
  output logic [N-1:0]   gnt_n
);
  import bus_arb_pkg::*;

  localparam int HW = (N_HI > 1) ? $clog2(N_HI) : 1;
  localparam int LW = (N_LO > 1) ? $clog2(N_LO) : 1;
  localparam logic [N-1:0] ONE_N = N'(1);

  // state
  logic           granted_q;
  logic [IDW-1:0] cur_q, cur_d;
  logic [HW-1:0]  hi_ptr_q, hi_ptr_d;
  logic [LW-1:0]  lo_ptr_q, lo_ptr_d;
  logic           hi_done_q, hi_done_d;
  logic           prev_idle_q;

  // decision inputs
  logic [N-1:0]   req;
  logic           hi_found, lo_found, any_req;
  logic [HW-1:0]  hi_idx;
  logic [LW-1:0]  lo_idx;
  logic [IDW-1:0] fx_idx;
  logic           consumed, holder_req, advance, hi_wrap, take_lo;
  pick_src_e      src;

  assign req = ~req_n;

  arb_rr_pick #(.W(N_HI)) u_hi_pick (
    .req   (req[N_HI-1:0]),
    .ptr   (hi_ptr_q),
    .found (hi_found),
    .idx   (hi_idx)
  );

  arb_rr_pick #(.W(N_LO)) u_lo_pick (
    .req   (req[N-1:N_HI]),
    .ptr   (lo_ptr_q),
    .found (lo_found),
    .idx   (lo_idx)
  );

  arb_prio_pick #(.W(N)) u_fix_pick (
    .req   (req),
    .found (any_req),
    .idx   (fx_idx)
  );

  // a grant is used up when its holder starts from an idle bus
  assign consumed   = granted_q && !frame_n && prev_idle_q;
  assign holder_req = req[cur_q];
  assign advance    = !granted_q || !holder_req || consumed;

  // the high tier wraps into a new pass: give the slot to tier two first
  assign hi_wrap = (hi_idx <= hi_ptr_q);
  assign take_lo = !hi_found || (hi_wrap && hi_done_q && lo_found);

  always_comb begin
    src = SRC_HOLD;
    if (advance) begin
      if (!any_req)         src = SRC_PARK;
      else if (!cfg_rotate) src = SRC_FIX;
      else if (take_lo)     src = SRC_LO;
      else                  src = SRC_HI;
    end
  end

  always_comb begin
    cur_d     = cur_q;
    hi_ptr_d  = hi_ptr_q;
    lo_ptr_d  = lo_ptr_q;
    hi_done_d = hi_done_q;
    case (src)
      SRC_PARK: cur_d = (granted_q && !cfg_park_last) ? cfg_park_id : cur_q;
      SRC_FIX:  cur_d = fx_idx;
      SRC_HI: begin
        cur_d     = IDW'(hi_idx);
        hi_ptr_d  = hi_idx;
        hi_done_d = 1'b1;
      end
      SRC_LO: begin
        cur_d     = IDW'(N_HI) + IDW'(lo_idx);
        lo_ptr_d  = lo_idx;
        hi_done_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      granted_q   <= 1'b0;
      cur_q       <= '0;
      hi_ptr_q    <= HW'(N_HI - 1);
      lo_ptr_q    <= LW'(N_LO - 1);
      hi_done_q   <= 1'b0;
      prev_idle_q <= 1'b1;
    end else begin
      prev_idle_q <= frame_n & irdy_n;
      granted_q   <= 1'b1;
      if (advance) begin
        cur_q     <= cur_d;
        hi_ptr_q  <= hi_ptr_d;
        lo_ptr_q  <= lo_ptr_d;
        hi_done_q <= hi_done_d;
      end
    end
  end

  always_comb begin
    gnt_n = '1;
    if (granted_q) gnt_n[cur_q] = 1'b0;
  end

  // ---------------- assertions ----------------
  assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  assert_hold_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (granted_q && ((~req_n & ~gnt_n) != '0) && !(!frame_n && prev_idle_q))
    |=> $stable(gnt_n));

  assert_grant_to_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (req_n != '1)) |=> ((~gnt_n & ~$past(req_n)) != '0));

  assert_fixed_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (req_n != '1) && !cfg_rotate)
    |=> ((~$past(req_n) & ((~gnt_n) - ONE_N)) == '0));

  assert_park_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_PARK && granted_q && !cfg_park_last && (int'(cfg_park_id) < N))
    |=> !gnt_n[$past(cfg_park_id)]);

endmodule

// File: tb/tb_bus_arb_two_tier.sv
module tb_bus_arb_two_tier;
  localparam int NH = 3;
  localparam int NL = 3;
  localparam int N  = NH + NL;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_n;
  logic         frame_n, irdy_n;
  logic         cfg_rotate, cfg_park_last;
  logic [2:0]   cfg_park_id;
  logic [N-1:0] gnt_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_arb_two_tier #(.N_HI(NH), .N_LO(NL)) dut (
    .clk, .rst_n, .req_n, .frame_n, .irdy_n,
    .cfg_rotate, .cfg_park_last, .cfg_park_id, .gnt_n
  );

  // ---------- reference model built from the requirements ----------
  logic m_gr, m_hd, m_pi;
  int   m_cur, m_hp, m_lp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gr <= 1'b0; m_cur <= 0; m_hp <= NH - 1; m_lp <= NL - 1;
      m_hd <= 1'b0; m_pi <= 1'b1;
    end else begin : mdl
      logic [N-1:0] rq;
      bit cons, adv;
      int hc, lc, fx;
      rq   = ~req_n;
      cons = m_gr && !frame_n && m_pi;
      adv  = !m_gr || !rq[m_cur] || cons;
      hc = -1; lc = -1; fx = -1;
      for (int k = 1; k <= NH; k++)
        if (hc < 0 && rq[(m_hp + k) % NH]) hc = (m_hp + k) % NH;
      for (int k = 1; k <= NL; k++)
        if (lc < 0 && rq[NH + (m_lp + k) % NL]) lc = (m_lp + k) % NL;
      for (int i = N - 1; i >= 0; i--) if (rq[i]) fx = i;
      m_pi <= frame_n & irdy_n;
      m_gr <= 1'b1;
      if (adv) begin
        if (rq == '0) begin
          if (m_gr && !cfg_park_last) m_cur <= int'(cfg_park_id);
        end else if (!cfg_rotate) begin
          m_cur <= fx;
        end else if (hc < 0 || (hc <= m_hp && m_hd && lc >= 0)) begin
          m_cur <= NH + lc; m_lp <= lc; m_hd <= 1'b0;
        end else begin
          m_cur <= hc; m_hp <= hc; m_hd <= 1'b1;
        end
      end
    end
  end

  function automatic logic [N-1:0] exp_gnt();
    logic [N-1:0] g;
    g = '1;
    if (m_gr) g[m_cur] = 1'b0;
    return g;
  endfunction

  function automatic int gid(logic [N-1:0] g);
    int r;
    r = -1;
    for (int i = N - 1; i >= 0; i--) if (!g[i]) r = i;
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    string t;
    @(negedge clk);
    t = cfg_rotate ? "R6 model" : "R8 model";
    chk(t, int'(gnt_n), int'(exp_gnt()));
    chk("R1 onehot", int'($countones(~gnt_n) <= 1), 1);
  endtask

  task automatic do_reset(input logic [N-1:0] rq);
    rst_n   = 1'b0;
    req_n   = ~rq;
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // reset with a fixed request set, then let each grant be consumed
  task automatic run_seq(input logic [N-1:0] rq, input int n, input int e[12], input string tag);
    do_reset(rq);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(tag, gid(gnt_n), e[i]);
      frame_n = 1'b0;
      tick();
      frame_n = 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    cfg_rotate = 1'b1; cfg_park_last = 1'b0; cfg_park_id = 3'd4;
    repeat (2) @(negedge clk);
    chk("R2 grants high in reset", int'(gnt_n), int'({N{1'b1}}));
    rst_n = 1'b1;
    tick(); chk("R2 first park on master 0", gid(gnt_n), 0);
    tick(); chk("R9 fixed park", gid(gnt_n), 4);
    req_n[2] = 1'b0; cfg_park_last = 1'b1;
    tick(); chk("R3 grant one edge after request", gid(gnt_n), 2);
    req_n[2] = 1'b1;
    tick(); chk("R10 park on last holder", gid(gnt_n), 2);
    tick(); chk("R10 park stays", gid(gnt_n), 2);

    // nested rotation
    cfg_rotate = 1'b1; cfg_park_last = 1'b0;
    run_seq(6'b111011, 12, '{0,1,3,0,1,4,0,1,5,0,1,3}, "R6 nested order");
    // skipping
    run_seq(6'b010010, 4, '{1,4,1,4,0,0,0,0,0,0,0,0}, "R7 skip idle slots");
    run_seq(6'b101000, 4, '{3,5,3,5,0,0,0,0,0,0,0,0}, "R7 tier two alone");
    run_seq(6'b000101, 4, '{0,2,0,2,0,0,0,0,0,0,0,0}, "R7 tier one alone");

    // hidden arbitration and hold
    do_reset(6'b000011);
    tick(); chk("R5 first owner", gid(gnt_n), 0);
    frame_n = 1'b0; irdy_n = 1'b0;
    tick(); chk("R5 grant moves while bus busy", gid(gnt_n), 1);
    chk("R5 bus still busy", int'(frame_n), 0);
    tick(); chk("R4 hold while waiting", gid(gnt_n), 1);
    tick(); chk("R4 hold while waiting", gid(gnt_n), 1);
    frame_n = 1'b1; irdy_n = 1'b1;
    tick(); chk("R4 hold over idle cycle", gid(gnt_n), 1);
    frame_n = 1'b0;
    tick(); chk("R5 start re-arbitrates", gid(gnt_n), 0);
    frame_n = 1'b1; req_n[0] = 1'b1;
    tick(); chk("R11 dropped request hands over", gid(gnt_n), 1);

    // fixed priority
    cfg_rotate = 1'b0;
    do_reset(6'b101100);
    tick(); chk("R8 lowest index wins", gid(gnt_n), 2);
    frame_n = 1'b0;
    tick(); chk("R8 winner kept after start", gid(gnt_n), 2);
    frame_n = 1'b1; req_n[2] = 1'b1;
    tick(); chk("R8 next lowest", gid(gnt_n), 3);

    // random phase
    cfg_rotate = 1'b1;
    do_reset('0);
    for (int c = 0; c < 3000; c++) begin
      if (c % 250 == 0) begin
        cfg_rotate    = 1'($urandom_range(1));
        cfg_park_last = 1'($urandom_range(1));
        cfg_park_id   = 3'($urandom_range(N - 1));
      end
      if ($urandom_range(3) == 0) req_n = N'($urandom);
      frame_n = ($urandom_range(2) != 0);
      irdy_n  = ($urandom_range(2) != 0);
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule